// File: doc/BRIEF.md
# Multiplexed Address/Data Bus Master

This block is the master side of an external bus that moves a 16-bit address and 16-bit data over a single set of shared lines. A bus clock E, produced inside the block as a fixed division of the system clock, splits every bus cycle into two halves. In the low half the shared lines carry the address. In the high half they carry the data. The target latches write data on the falling edge of E, and the master captures read data on that same edge.

The client side is a simple request port. When the master is idle it takes an address, write data, a write flag and a byte flag in one clock. It then runs the access on the bus and reports completion with a one-clock done pulse that carries the read data. One access can move a whole 16-bit word or a single byte. An active-low low-lane strobe tells the target whether the low byte lane (AD7..0) is in use. The addressing is big-endian: an even address selects the high lane (AD15..8) and an odd address selects the low lane.

A word request at an odd address has two build-time outcomes. With `SPLIT_ODD=1` it becomes two back-to-back byte cycles. With `SPLIT_ODD=0` it is refused with an error and nothing appears on the bus.

Top module: `muxbus_master`

## Requirements
- R1: E runs continuously from reset with a period of 2*E_HALF system clocks: E_HALF clocks low, then E_HALF clocks high. E is low during reset and in the first cycle after it.
- R2: During the E-low half of an active bus cycle, ad_o carries the full access address and ad_oe_o is 1. A request produces exactly the bus cycles its kind calls for and no others.
- R3: In a write cycle rw_o is 0 for the whole cycle. ad_oe_o stays 1 through the E-high half, and ad_o carries the write data there. For a word this is req_wdata_i[15:0]; for a byte it is the byte repeated on both lanes.
- R4: In a read cycle rw_o is 1 and ad_oe_o is 0 during the E-high half. The data is sampled from ad_i at the clock edge on which E falls. A word read returns ad_i[15:0].
- R5: lo_strb_no is 0 in cycles that use the low lane (word cycles and byte cycles at odd addresses) and 1 in byte cycles at even addresses and when no cycle is active. A byte at an even address uses lane AD15..8; at an odd address it uses AD7..0.
- R6: A byte read returns {8'h00, selected lane}. A byte write takes its value from req_wdata_i[7:0].
- R7: req_ready_o is 1 only when idle, and a request is taken only on a clock where req_valid_i and req_ready_o are both 1. req_valid_i has no effect while req_ready_o is 0.
- R8: done_o is a single-clock pulse per accepted request, and rdata_o is valid with it for reads. err_o is 1 only together with done_o.
- R9: An accepted access starts its bus cycle at the start of an E-low half. While idle, ad_oe_o=0, rw_o=1 and lo_strb_no=1.
- R10: With SPLIT_ODD=1, a word at odd address A runs two back-to-back byte cycles. The first is at A on the low lane with req_wdata_i[15:8]. The second is at A+1 on the high lane with req_wdata_i[7:0]. One done pulse follows, and a read returns {byte at A, byte at A+1}.
- R11: With SPLIT_ODD=0, a word at an odd address completes with done_o and err_o both 1 and drives no bus cycle. All other accesses run normally with err_o=0.
- R12: The second half of a split access wraps its address modulo 2^16, so address 16'hFFFF is followed by 16'h0000.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_valid_i | input | 1 | Request present |
| req_ready_o | output | 1 | Master idle, request can be taken |
| req_addr_i | input | 16 | Byte address of the access |
| req_wdata_i | input | 16 | Write data (byte in bits 7..0) |
| req_write_i | input | 1 | 1 = write, 0 = read |
| req_byte_i | input | 1 | 1 = single byte, 0 = 16-bit word |
| done_o | output | 1 | One-clock completion pulse |
| err_o | output | 1 | Request refused (odd word, reject variant) |
| rdata_o | output | 16 | Read data, valid with done_o |
| e_o | output | 1 | Bus clock E |
| rw_o | output | 1 | 1 = read cycle or idle, 0 = write cycle |
| lo_strb_no | output | 1 | Low byte lane in use, active low |
| ad_o | output | 16 | Shared lines, driven value |
| ad_oe_o | output | 1 | Tri-state enable for the shared lines |
| ad_i | input | 16 | Shared lines, sampled value |

## Verification
The checker watches the properties that hold on every cycle. These are the E half lengths, a stable address during the E-low half, bus release during the E-high half of reads, and continuous drive in write cycles. It also covers lane strobing at odd addresses, the idle bus state and the single-clock done and error pulses. Some outcomes only a scenario can show: which address and data each bus cycle carries, how a split access is ordered and wraps at 16'hFFFF, and which byte lane a read returns. The same holds for a request held while busy leaving no trace, and for the reject variant driving no bus cycle at all. The bench covers these with a bus-cycle scoreboard, a response scoreboard and a second instance built with SPLIT_ODD=0.

// File: rtl/muxbus_pkg.sv
package muxbus_pkg;
  typedef enum logic [1:0] {ST_IDLE, ST_PEND, ST_BUS, ST_REJ} seq_st_e;
  // SPLIT_HI: first half of an odd word (address A), SPLIT_LO: second half (A+1)
  typedef enum logic [1:0] {AK_WORD, AK_BYTE, AK_SPLIT_HI, AK_SPLIT_LO} acc_kind_e;
endpackage

// File: rtl/muxbus_eclk.sv
module muxbus_eclk #(
  parameter int unsigned E_HALF = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  output logic e_o,
  output logic ph_last_o
);
  localparam int unsigned PER = 2 * E_HALF;
  localparam int unsigned PHW = (PER > 2) ? $clog2(PER) : 1;

  logic [PHW-1:0] ph_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                       ph_q <= '0;
    else if (ph_q == PHW'(PER - 1))    ph_q <= '0;
    else                               ph_q <= ph_q + PHW'(1);
  end

  assign e_o       = (ph_q >= PHW'(E_HALF));
  assign ph_last_o = (ph_q == PHW'(PER - 1));
endmodule

// File: rtl/muxbus_seq.sv
module muxbus_seq
  import muxbus_pkg::*;
#(
  parameter int unsigned BUS_W     = 16,
  parameter bit          SPLIT_ODD = 1'b1
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             ph_last_i,
  input  logic             req_valid_i,
  output logic             req_ready_o,
  input  logic [BUS_W-1:0] req_addr_i,
  input  logic [BUS_W-1:0] req_wdata_i,
  input  logic             req_write_i,
  input  logic             req_byte_i,
  output logic             cyc_act_o,
  output logic [BUS_W-1:0] cyc_addr_o,
  output logic [BUS_W-1:0] cyc_wdata_o,
  output logic             cyc_write_o,
  output acc_kind_e        cyc_kind_o,
  output logic             done_o,
  output logic             err_o
);
  seq_st_e          st_q;
  logic [BUS_W-1:0] addr_q, wdata_q;
  logic             write_q, done_q, err_q;
  acc_kind_e        kind_q;
  logic             odd_word, reject;

  assign odd_word = !req_byte_i && req_addr_i[0];

  if (SPLIT_ODD) begin : g_split
    assign reject = 1'b0;
  end else begin : g_reject
    assign reject = odd_word;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q    <= ST_IDLE;
      addr_q  <= '0;
      wdata_q <= '0;
      write_q <= 1'b0;
      kind_q  <= AK_WORD;
      done_q  <= 1'b0;
      err_q   <= 1'b0;
    end else begin
      done_q <= 1'b0;
      err_q  <= 1'b0;
      unique case (st_q)
        ST_IDLE: if (req_valid_i) begin
          addr_q  <= req_addr_i;
          wdata_q <= req_wdata_i;
          write_q <= req_write_i;
          if (req_byte_i)    kind_q <= AK_BYTE;
          else if (odd_word) kind_q <= AK_SPLIT_HI;
          else               kind_q <= AK_WORD;
          if (reject)         st_q <= ST_REJ;
          else if (ph_last_i) st_q <= ST_BUS;  // next clock opens an E-low half
          else                st_q <= ST_PEND;
        end
        ST_REJ: begin
          done_q <= 1'b1;
          err_q  <= 1'b1;
          st_q   <= ST_IDLE;
        end
        ST_PEND: if (ph_last_i) st_q <= ST_BUS;
        ST_BUS: if (ph_last_i) begin
          if (kind_q == AK_SPLIT_HI) begin
            kind_q <= AK_SPLIT_LO;
            addr_q <= addr_q + BUS_W'(1);
          end else begin
            done_q <= 1'b1;
            st_q   <= ST_IDLE;
          end
        end
        default: st_q <= ST_IDLE;
      endcase
    end
  end

  assign req_ready_o = (st_q == ST_IDLE);
  assign cyc_act_o   = (st_q == ST_BUS);
  assign cyc_addr_o  = addr_q;
  assign cyc_wdata_o = wdata_q;
  assign cyc_write_o = write_q;
  assign cyc_kind_o  = kind_q;
  assign done_o      = done_q;
  assign err_o       = err_q;
endmodule

// File: rtl/muxbus_lanes.sv
module muxbus_lanes
  import muxbus_pkg::*;
#(
  parameter int unsigned BYTE_W = 8
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                e_i,
  input  logic                ph_last_i,
  input  logic                cyc_act_i,
  input  logic [2*BYTE_W-1:0] cyc_addr_i,
  input  logic [2*BYTE_W-1:0] cyc_wdata_i,
  input  logic                cyc_write_i,
  input  acc_kind_e           cyc_kind_i,
  input  logic [2*BYTE_W-1:0] ad_i,
  output logic [2*BYTE_W-1:0] ad_o,
  output logic                ad_oe_o,
  output logic                rw_o,
  output logic                lo_strb_no,
  output logic [2*BYTE_W-1:0] rdata_o
);
  localparam int unsigned BUS_W = 2 * BYTE_W;

  logic              is_word;
  logic [BYTE_W-1:0] wr_byte, rd_lane;
  logic [BUS_W-1:0]  wr_bus, rdata_q;

  assign is_word = (cyc_kind_i == AK_WORD);
  assign wr_byte = (cyc_kind_i == AK_SPLIT_HI) ? cyc_wdata_i[BUS_W-1:BYTE_W]
                                                : cyc_wdata_i[BYTE_W-1:0];
  assign wr_bus  = is_word ? cyc_wdata_i : {wr_byte, wr_byte};
  // big-endian lanes: even address on the upper lane
  assign rd_lane = cyc_addr_i[0] ? ad_i[BYTE_W-1:0] : ad_i[BUS_W-1:BYTE_W];

  always_comb begin
    ad_o = '0;
    if (cyc_act_i) begin
      if (!e_i)             ad_o = cyc_addr_i;
      else if (cyc_write_i) ad_o = wr_bus;
    end
  end

  assign ad_oe_o    = cyc_act_i && (!e_i || cyc_write_i);
  assign rw_o       = !(cyc_act_i && cyc_write_i);
  assign lo_strb_no = !(cyc_act_i && (is_word || cyc_addr_i[0]));

  // ph_last edge is the one on which E falls
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rdata_q <= '0;
    end else if (cyc_act_i && !cyc_write_i && ph_last_i) begin
      unique case (cyc_kind_i)
        AK_WORD:     rdata_q                    <= ad_i;
        AK_BYTE:     rdata_q                    <= {{BYTE_W{1'b0}}, rd_lane};
        AK_SPLIT_HI: rdata_q[BUS_W-1:BYTE_W]    <= rd_lane;
        AK_SPLIT_LO: rdata_q[BYTE_W-1:0]        <= rd_lane;
        default:     rdata_q                    <= rdata_q;
      endcase
    end
  end

  assign rdata_o = rdata_q;
endmodule

// File: rtl/muxbus_master.sv
module muxbus_master
  import muxbus_pkg::*;
#(
  parameter int unsigned BYTE_W    = 8,
  parameter int unsigned E_HALF    = 2,
  parameter bit          SPLIT_ODD = 1'b1
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                req_valid_i,
  output logic                req_ready_o,
  input  logic [2*BYTE_W-1:0] req_addr_i,
  input  logic [2*BYTE_W-1:0] req_wdata_i,
  input  logic                req_write_i,
  input  logic                req_byte_i,
  output logic                done_o,
  output logic                err_o,
  output logic [2*BYTE_W-1:0] rdata_o,
  output logic                e_o,
  output logic                rw_o,
  output logic                lo_strb_no,
  output logic [2*BYTE_W-1:0] ad_o,
  output logic                ad_oe_o,
  input  logic [2*BYTE_W-1:0] ad_i
);
  localparam int unsigned BUS_W = 2 * BYTE_W;

  logic             ph_last, cyc_act, cyc_write;
  logic [BUS_W-1:0] cyc_addr, cyc_wdata;
  acc_kind_e        cyc_kind;

  muxbus_eclk #(.E_HALF(E_HALF)) i_eclk (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .e_o       (e_o),
    .ph_last_o (ph_last)
  );

  muxbus_seq #(.BUS_W(BUS_W), .SPLIT_ODD(SPLIT_ODD)) i_seq (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .ph_last_i   (ph_last),
    .req_valid_i (req_valid_i),
    .req_ready_o (req_ready_o),
    .req_addr_i  (req_addr_i),
    .req_wdata_i (req_wdata_i),
    .req_write_i (req_write_i),
    .req_byte_i  (req_byte_i),
    .cyc_act_o   (cyc_act),
    .cyc_addr_o  (cyc_addr),
    .cyc_wdata_o (cyc_wdata),
    .cyc_write_o (cyc_write),
    .cyc_kind_o  (cyc_kind),
    .done_o      (done_o),
    .err_o       (err_o)
  );

  muxbus_lanes #(.BYTE_W(BYTE_W)) i_lanes (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .e_i         (e_o),
    .ph_last_i   (ph_last),
    .cyc_act_i   (cyc_act),
    .cyc_addr_i  (cyc_addr),
    .cyc_wdata_i (cyc_wdata),
    .cyc_write_i (cyc_write),
    .cyc_kind_i  (cyc_kind),
    .ad_i        (ad_i),
    .ad_o        (ad_o),
    .ad_oe_o     (ad_oe_o),
    .rw_o        (rw_o),
    .lo_strb_no  (lo_strb_no),
    .rdata_o     (rdata_o)
  );
endmodule

// File: rtl/muxbus_master_chk.sv
module muxbus_master_chk #(
  parameter int unsigned BUS_W  = 16,
  parameter int unsigned E_HALF = 2
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             e_o,
  input logic [BUS_W-1:0] ad_o,
  input logic             ad_oe_o,
  input logic             rw_o,
  input logic             lo_strb_no,
  input logic             done_o,
  input logic             err_o,
  input logic             req_ready_o
);
  localparam int unsigned RW = $clog2(E_HALF + 1) + 1;

  logic          e_d;
  logic [RW-1:0] run_q;

  // run_q: clocks E has held the value it had in the previous cycle
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      e_d   <= 1'b0;
      run_q <= '0;
    end else begin
      e_d   <= e_o;
      run_q <= (e_o != e_d) ? RW'(1) : run_q + RW'(1);
    end
  end

  p_e_half_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (e_o != e_d) |-> (run_q == RW'(E_HALF)));
  p_e_bound_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    run_q <= RW'(E_HALF));
  p_addr_stable_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!e_o && !$past(e_o) && ad_oe_o) |-> ($stable(ad_o) && $past(ad_oe_o)));
  p_wr_drive_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !rw_o |-> ad_oe_o);
  p_rd_release_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (e_o && rw_o) |-> !ad_oe_o);
  p_odd_strobe_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ad_oe_o && !e_o && ad_o[0]) |-> !lo_strb_no);
  p_done_ready_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> req_ready_o);
  p_done_pulse_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);
  p_err_done_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    err_o |-> done_o);
  p_idle_bus_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_ready_o |-> (!ad_oe_o && rw_o && lo_strb_no));
endmodule

bind muxbus_master muxbus_master_chk #(.BUS_W(2 * BYTE_W), .E_HALF(E_HALF)) i_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .e_o         (e_o),
  .ad_o        (ad_o),
  .ad_oe_o     (ad_oe_o),
  .rw_o        (rw_o),
  .lo_strb_no  (lo_strb_no),
  .done_o      (done_o),
  .err_o       (err_o),
  .req_ready_o (req_ready_o)
);

// File: tb/test_muxbus_master.sv
`timescale 1ns/1ps
module test_muxbus_master;
  typedef struct { bit is_rd; logic [15:0] rdata; bit err; string tag; } sb_t;
  typedef struct { logic [15:0] addr; bit rw; bit ls_n; logic [15:0] wd; string tag; } bus_t;

  logic clk = 1'b0, rst_n = 1'b0;
  always #5 clk = ~clk;

  // main instance: odd words split
  logic        req_valid = 0, req_write = 0, req_byte = 0;
  logic [15:0] req_addr = '0, req_wdata = '0;
  logic        req_ready, done, err, e, rw, ls_n, ad_oe;
  logic [15:0] rdata, ad_out, ad_in;

  muxbus_master #(.SPLIT_ODD(1'b1)) i_muxbus_master (
    .clk_i(clk), .rst_ni(rst_n), .req_valid_i(req_valid), .req_ready_o(req_ready),
    .req_addr_i(req_addr), .req_wdata_i(req_wdata), .req_write_i(req_write),
    .req_byte_i(req_byte), .done_o(done), .err_o(err), .rdata_o(rdata), .e_o(e),
    .rw_o(rw), .lo_strb_no(ls_n), .ad_o(ad_out), .ad_oe_o(ad_oe), .ad_i(ad_in));

  // second instance: odd words rejected
  logic        r_valid = 0, r_write = 0, r_byte = 0;
  logic [15:0] r_addr = '0;
  logic        r_ready, r_done, r_err, r_e, r_rw, r_ls_n, r_oe;
  logic [15:0] r_rdata, r_ad_out;

  muxbus_master #(.SPLIT_ODD(1'b0)) i_muxbus_master_rej (
    .clk_i(clk), .rst_ni(rst_n), .req_valid_i(r_valid), .req_ready_o(r_ready),
    .req_addr_i(r_addr), .req_wdata_i(16'h1357), .req_write_i(r_write),
    .req_byte_i(r_byte), .done_o(r_done), .err_o(r_err), .rdata_o(r_rdata), .e_o(r_e),
    .rw_o(r_rw), .lo_strb_no(r_ls_n), .ad_o(r_ad_out), .ad_oe_o(r_oe), .ad_i(16'h0000));

  int n_chk = 0, n_err = 0;
  sb_t  sb_q[$];
  bus_t bus_q[$];
  logic [7:0] mmem [logic [15:0]];  // bench model
  logic [7:0] rmem [logic [15:0]];  // responder storage

  function automatic logic [7:0] init_b(input logic [15:0] a);
    return a[7:0] ^ a[15:8] ^ 8'h3C;
  endfunction
  function automatic logic [7:0] mget(input logic [15:0] a);
    return mmem.exists(a) ? mmem[a] : init_b(a);
  endfunction
  function automatic logic [7:0] rget(input logic [15:0] a);
    return rmem.exists(a) ? rmem[a] : init_b(a);
  endfunction

  task automatic chk(input bit ok, input string tag, input string what,
                     input logic [15:0] act, input logic [15:0] exp);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s %s act=%h exp=%h", tag, what, act, exp);
    end
  endtask

  // driver: push expected bus cycles and response, then issue the request
  task automatic req(input logic [15:0] a, input logic [15:0] w, input bit wr,
                     input bit by, input string tag);
    sb_t s; bus_t b; logic [15:0] a1;
    a1 = a + 16'd1;
    s.is_rd = !wr; s.err = 1'b0; s.tag = tag; s.rdata = '0;
    if (by) begin
      b = '{a, !wr, !a[0], {w[7:0], w[7:0]}, tag}; bus_q.push_back(b);
      if (wr) mmem[a] = w[7:0]; else s.rdata = {8'h00, mget(a)};
    end else begin
      if (!a[0]) begin
        b = '{a, !wr, 1'b0, w, tag}; bus_q.push_back(b);
      end else begin
        b = '{a, !wr, 1'b0, {w[15:8], w[15:8]}, tag}; bus_q.push_back(b);
        b = '{a1, !wr, 1'b1, {w[7:0], w[7:0]}, tag}; bus_q.push_back(b);
      end
      if (wr) begin mmem[a] = w[15:8]; mmem[a1] = w[7:0]; end
      else s.rdata = {mget(a), mget(a1)};
    end
    sb_q.push_back(s);
    @(negedge clk);
    req_addr = a; req_wdata = w; req_write = wr; req_byte = by; req_valid = 1'b1;
    while (!req_ready) @(negedge clk);
    @(negedge clk);
    req_valid = 1'b0;
  endtask

  task automatic wait_idle();
    while (sb_q.size() != 0 || bus_q.size() != 0) @(negedge clk);
    @(negedge clk);
  endtask

  // response monitor
  always @(negedge clk) begin
    if (rst_n && done) begin
      if (sb_q.size() == 0) begin
        chk(1'b0, "R8", "done without request", {15'd0, done}, 16'd0);
      end else begin
        sb_t s;
        s = sb_q.pop_front();
        chk(err == s.err, s.tag, "err", {15'd0, err}, {15'd0, s.err});
        if (s.is_rd) chk(rdata == s.rdata, s.tag, "rdata", rdata, s.rdata);
      end
    end
  end

  // target responder and bus-cycle monitor
  logic        e_prev = 1'b0, cyc_seen = 1'b0, c_rw = 1'b1, c_ls = 1'b1;
  logic [15:0] c_addr = '0, c_wd = '0, drv = 16'hA5A5;
  assign ad_in = drv;

  always @(negedge clk) begin
    if (rst_n) begin
      if (e_prev && !e && cyc_seen) begin  // E has fallen: target latches here
        if (!c_rw) begin
          if (!c_addr[0]) begin
            rmem[c_addr] = c_wd[15:8];
            if (!c_ls) rmem[c_addr | 16'd1] = c_wd[7:0];
          end else begin
            rmem[c_addr] = c_wd[7:0];
          end
        end
        if (bus_q.size() == 0) begin
          chk(1'b0, "R2", "unexpected bus cycle", c_addr, 16'h0);
        end else begin
          bus_t b;
          b = bus_q.pop_front();
          chk(c_addr == b.addr, "R2", "address phase", c_addr, b.addr);
          chk(c_rw == b.rw, b.tag, "rw", {15'd0, c_rw}, {15'd0, b.rw});
          chk(c_ls == b.ls_n, "R5", "low strobe", {15'd0, c_ls}, {15'd0, b.ls_n});
          if (!b.rw) chk(c_wd == b.wd, b.tag, "write data", c_wd, b.wd);
        end
        cyc_seen = 1'b0;
      end
      if (!e) begin
        if (ad_oe) begin
          cyc_seen = 1'b1; c_addr = ad_out; c_rw = rw; c_ls = ls_n;
        end
      end else if (cyc_seen && !c_rw) begin
        c_wd = ad_out;
      end
      drv = (e && cyc_seen && c_rw) ? {rget(c_addr & 16'hFFFE), rget(c_addr | 16'd1)}
                                    : 16'hA5A5;
      e_prev = e;
    end
  end

  task automatic rej_req(input logic [15:0] a, input bit wr, input bit by,
                         input bit exp_err, input int exp_oe, input string tag);
    int oe_cnt;
    @(negedge clk);
    r_addr = a; r_write = wr; r_byte = by; r_valid = 1'b1;
    while (!r_ready) @(negedge clk);
    @(negedge clk);
    r_valid = 1'b0;
    oe_cnt = 0;
    while (!r_done) begin
      if (r_oe) oe_cnt++;
      @(negedge clk);
    end
    chk(r_err == exp_err, tag, "reject err", {15'd0, r_err}, {15'd0, exp_err});
    chk(oe_cnt == exp_oe, tag, "drive clocks", 16'(oe_cnt), 16'(exp_oe));
  endtask

  bit finished = 1'b0;

  initial begin
    repeat (3) @(negedge clk);
    // reset state R1, R7, R9
    chk(e == 1'b0, "R1", "E in reset", {15'd0, e}, 16'd0);
    chk(ad_oe == 1'b0 && rw == 1'b1 && ls_n == 1'b1, "R9", "idle bus in reset",
        {13'd0, ad_oe, rw, ls_n}, 16'b011);
    chk(done == 1'b0 && err == 1'b0, "R8", "no done in reset", {14'd0, done, err}, 16'd0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(e == 1'b0, "R1", "E low after reset", {15'd0, e}, 16'd0);
    chk(req_ready == 1'b1, "R7", "ready when idle", {15'd0, req_ready}, 16'd1);

    // word write and read R2, R3, R4
    req(16'h0400, 16'h1234, 1, 0, "R3");
    req(16'h0400, 16'h0000, 0, 0, "R4");
    req(16'h2000, 16'h0000, 0, 0, "R4");
    // byte lanes R5, R6
    req(16'h0401, 16'h00AB, 1, 1, "R6");
    req(16'h0402, 16'hFFCD, 1, 1, "R6");
    req(16'h0400, 16'h0000, 0, 0, "R5");
    req(16'h0402, 16'h0000, 0, 1, "R6");
    req(16'h0401, 16'h0000, 0, 1, "R6");
    // split odd word R10
    req(16'h0403, 16'h5566, 1, 0, "R10");
    req(16'h0402, 16'h0000, 0, 0, "R10");
    req(16'h0403, 16'h0000, 0, 0, "R10");
    // wrap R12
    req(16'h0000, 16'h0077, 1, 1, "R12");
    req(16'hFFFF, 16'h0088, 1, 1, "R12");
    req(16'hFFFF, 16'h0000, 0, 0, "R12");
    req(16'hFFFF, 16'h99AA, 1, 0, "R12");
    req(16'h0000, 16'h0000, 0, 1, "R12");
    wait_idle();

    // R7: valid while busy is ignored
    req(16'h0100, 16'h0000, 0, 0, "R7");
    req_addr = 16'h0100; req_wdata = 16'hDEAD; req_write = 1'b1; req_byte = 1'b0;
    req_valid = 1'b1;
    repeat (2) @(negedge clk);
    req_valid = 1'b0;
    wait_idle();
    req(16'h0100, 16'h0000, 0, 0, "R7");

    // mixed traffic R2, R9
    for (int i = 0; i < 12; i++) begin
      logic [15:0] a, w;
      a = 16'h3000 + 16'(i * 5);
      w = 16'hA000 ^ 16'(i * 16'h0123);
      req(a, w, (i % 4) < 2, (i % 2) == 1, "R9");
    end
    for (int i = 0; i < 12; i++) req(16'h3000 + 16'(i * 5), 16'h0, 0, 0, "R2");
    wait_idle();
    chk(bus_q.size() == 0 && sb_q.size() == 0, "R2", "queues drained",
        16'(bus_q.size()), 16'd0);

    // reject variant R11
    rej_req(16'h0011, 1, 0, 1, 0, "R11");
    rej_req(16'h0023, 0, 0, 1, 0, "R11");
    rej_req(16'h0020, 1, 0, 0, 4, "R11");
    rej_req(16'h0021, 0, 1, 0, 2, "R11");

    finished = 1'b1;
    $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
    $finish;
  end

  initial begin
    repeat (50000) @(posedge clk);
    if (!finished) begin
      n_chk++; n_err++;
      $display("FAIL watchdog expired act=running exp=finished");
      $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
      $finish;
    end
  end
endmodule